// File: doc/BRIEF.md
# Shared Save FIFO with Staging Slots

This block records register values read on two source buses into one shared history FIFO, so that a register file can later be restored after a short rollback. Each bus comes with a save bit that marks whether its value must be kept. The FIFO has one entry point. The block therefore offers four ways to handle an instruction that asks for both values in the same cycle.

- **Split-cycle mode:** the FIFO takes two writes in one cycle.
- **Serial mode:** the second value costs one stall cycle.
- **Staged mode:** one single-entry slot per bus parks the extra value and writes it on a later cycle.
- **Cross-staged mode:** the same as staged mode, except that either bus may use either slot.

When the FIFO is full, each new write pushes out the oldest entry. The block reports its stall request, the values written in each cycle, the fill level and the oldest retained value. When the block raises stall, the producer must present the same save bits and data again in the next cycle.

Top module: `srcsave_fifo`

## Requirements
- R1: After reset the fill level is 0, stall is low, no write occurs while no save bit is set, and split-cycle mode (code 0) is active.
- R2: In split-cycle mode (mode_sel code 0), when both save bits are set, the FIFO takes two writes in that cycle: wr_cnt is 2, wr_first is the source-1 value and wr_second is the source-2 value. Stall stays low in this mode.
- R3: In serial mode (code 1), a cycle with both save bits set writes the source-1 value and raises stall. With the inputs held, the next cycle writes the source-2 value with stall low. A single save writes without stall.
- R4: In staged mode (code 2), when both save bits are set and the staging slots are empty, the source-1 value is written at once and the source-2 value is parked without stall. The parked value is written in the next cycle.
- R5: In both staged modes (codes 2 and 3), the FIFO takes at most one write per cycle. Parked values are written oldest first, with source 1 ahead of source 2 for the same instruction, and before any newer save.
- R6: In staged mode, a save that needs its own bus slot (source 1 uses slot 0, source 2 uses slot 1) while that slot is still busy after this cycle's drain raises stall. None of the instruction's saves is accepted, but the oldest parked value is still written.
- R7: In cross-staged mode (code 3), a save whose own slot is busy takes the other slot if that slot is free, and no stall is raised.
- R8: The fill level rises by the number of writes and stops at DEPTH. Once the FIFO is full, each write discards the oldest entry, and `oldest` always shows the oldest retained value.
- R9: mode_sel is taken only in a cycle where the FIFO, both staging slots and the serial pending state are all empty. At all other times it has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| mode_sel | input | 2 | Arbitration mode: 0 split, 1 serial, 2 staged, 3 cross-staged |
| src1_save | input | 1 | Source-1 value must be kept |
| src1_data | input | DW | Source-1 bus value |
| src2_save | input | 1 | Source-2 value must be kept |
| src2_data | input | DW | Source-2 bus value |
| stall | output | 1 | Instruction must be held and offered again next cycle |
| wr_cnt | output | 2 | FIFO writes in this cycle (0 to 2) |
| wr_first | output | DW | Value of the first write this cycle |
| wr_second | output | DW | Value of the second write (valid when wr_cnt is 2) |
| fill | output | CW | Entries held in the FIFO |
| oldest | output | DW | Oldest retained entry (valid when fill is non-zero) |

## Verification
A corrupted staging slot or age bit shows up in the same cycle it drains: `wr_first` carries the wrong value or the wrong order within one or two cycles of a paired save. A wrong slot-occupancy view shows up as a stall that should not occur, or a missing one, on the next save that needs a slot. Errors in the ring pointer or fill count show up in `oldest` and `fill` one cycle after the write, and the bench compares both every cycle. A mode latched at the wrong time changes wr_cnt or stall on the first paired save that follows.

// File: rtl/srcsave_pkg.sv
package srcsave_pkg;
  typedef enum logic [1:0] {
    MODE_SPLIT   = 2'd0,
    MODE_SERIAL  = 2'd1,
    MODE_STAGED  = 2'd2,
    MODE_XSTAGED = 2'd3
  } save_mode_e;
endpackage

// File: rtl/srcsave_rst_sync.sv
module srcsave_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [1:0] shift_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) shift_q <= 2'b00;
    else        shift_q <= {shift_q[0], 1'b1};
  end

  assign rst_n_sync = shift_q[1];
endmodule

// File: rtl/srcsave_arb.sv
module srcsave_arb
  import srcsave_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [1:0]    mode_sel,
  input  logic          fifo_empty,
  input  logic          s1_save,
  input  logic [DW-1:0] s1_data,
  input  logic          s2_save,
  input  logic [DW-1:0] s2_data,
  output logic          stall,
  output logic [1:0]    wr_cnt,
  output logic [DW-1:0] wr_a,
  output logic [DW-1:0] wr_b,
  output save_mode_e    mode_q
);
  localparam int NSLOT = 2;

  save_mode_e       mode_n;
  logic             pend_q, pend_n;
  logic [NSLOT-1:0] sv_q, sv_n, ld;
  logic             old_q, old_n;
  logic [DW-1:0]    sd_q   [NSLOT];
  logic [DW-1:0]    ld_dat [NSLOT];

  logic staged_md, xmode, has_stg, drain, fr0, fr1, need1, need2;
  logic p1_ok, p1_slot, p2_ok, p2_slot, f0b, f1b, fail, rem, all_empty;

  assign staged_md = (mode_q == MODE_STAGED) || (mode_q == MODE_XSTAGED);
  assign xmode     = (mode_q == MODE_XSTAGED);
  assign has_stg   = sv_q[0] | sv_q[1];
  assign drain     = (sv_q[0] & sv_q[1]) ? old_q : sv_q[1];
  assign fr0       = ~sv_q[0] | (has_stg & ~drain);
  assign fr1       = ~sv_q[1] | (has_stg & drain);
  assign rem       = sv_q[0] & sv_q[1];
  assign need1     = has_stg & s1_save;
  assign need2     = s2_save & (has_stg | s1_save);
  assign all_empty = fifo_empty & ~sv_q[0] & ~sv_q[1] & ~pend_q;

  // slot placement: own slot first, other slot only in cross mode
  always_comb begin
    p1_ok = 1'b1; p1_slot = 1'b0;
    if (fr0)                p1_slot = 1'b0;
    else if (xmode && fr1)  p1_slot = 1'b1;
    else                    p1_ok   = 1'b0;
    f0b = fr0 & ~(need1 & p1_ok & ~p1_slot);
    f1b = fr1 & ~(need1 & p1_ok & p1_slot);
    p2_ok = 1'b1; p2_slot = 1'b1;
    if (f1b)                p2_slot = 1'b1;
    else if (xmode && f0b)  p2_slot = 1'b0;
    else                    p2_ok   = 1'b0;
    fail = staged_md & ((need1 & ~p1_ok) | (need2 & ~p2_ok));
  end

  always_comb begin
    stall     = 1'b0;
    wr_cnt    = 2'd0;
    wr_a      = s1_save ? s1_data : s2_data;
    wr_b      = s2_data;
    pend_n    = pend_q;
    sv_n      = sv_q;
    old_n     = old_q;
    ld        = '0;
    ld_dat[0] = s1_data;
    ld_dat[1] = s2_data;
    mode_n    = all_empty ? save_mode_e'(mode_sel) : mode_q;
    case (mode_q)
      MODE_SPLIT: begin
        wr_cnt = {1'b0, s1_save} + {1'b0, s2_save};
        pend_n = 1'b0;
      end
      MODE_SERIAL: begin
        if (s1_save && s2_save) begin
          wr_cnt = 2'd1;
          if (!pend_q) begin
            wr_a   = s1_data;
            stall  = 1'b1;
            pend_n = 1'b1;
          end else begin
            wr_a   = s2_data;
            pend_n = 1'b0;
          end
        end else begin
          wr_cnt = {1'b0, s1_save | s2_save};
          pend_n = 1'b0;
        end
      end
      default: begin
        stall = fail;
        if (has_stg) begin
          wr_cnt      = 2'd1;
          wr_a        = drain ? sd_q[1] : sd_q[0];
          sv_n[drain] = 1'b0;
          if (rem) old_n = ~drain;
        end else if (s1_save || s2_save) begin
          wr_cnt = 2'd1;
        end
        if (!fail) begin
          if (need1) begin
            ld[p1_slot]     = 1'b1;
            ld_dat[p1_slot] = s1_data;
            sv_n[p1_slot]   = 1'b1;
          end
          if (need2) begin
            ld[p2_slot]     = 1'b1;
            ld_dat[p2_slot] = s2_data;
            sv_n[p2_slot]   = 1'b1;
          end
          if (need1 || need2) begin
            if (rem)        old_n = ~drain;
            else if (need1) old_n = p1_slot;
            else            old_n = p2_slot;
          end
        end
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= MODE_SPLIT;
      pend_q <= 1'b0;
      sv_q   <= '0;
      old_q  <= 1'b0;
    end else begin
      mode_q <= mode_n;
      pend_q <= pend_n;
      sv_q   <= sv_n;
      old_q  <= old_n;
    end
  end

  for (genvar g = 0; g < NSLOT; g++) begin : g_slot
    always_ff @(posedge clk) begin
      if (ld[g]) sd_q[g] <= ld_dat[g];
    end
  end
endmodule

// File: rtl/srcsave_ring.sv
module srcsave_ring #(
  parameter int DW    = 8,
  parameter int DEPTH = 8,
  localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [1:0]    wr_cnt,
  input  logic [DW-1:0] wr_a,
  input  logic [DW-1:0] wr_b,
  output logic [CW-1:0] fill,
  output logic [DW-1:0] oldest
);
  localparam int PW = CW + 1;

  logic [AW-1:0] wp_q, wp_n, wp1, wp2, head;
  logic [CW-1:0] fill_q, fill_n;
  logic [PW-1:0] sum, hx;
  logic [DEPTH-1:0][DW-1:0] view;

  always_comb begin
    wp1  = (wp_q == AW'(DEPTH - 1)) ? '0 : wp_q + AW'(1);
    wp2  = (wp1  == AW'(DEPTH - 1)) ? '0 : wp1 + AW'(1);
    wp_n = (wr_cnt == 2'd0) ? wp_q : (wr_cnt == 2'd1) ? wp1 : wp2;
    sum  = PW'(fill_q) + PW'(wr_cnt);
    fill_n = (sum > PW'(DEPTH)) ? CW'(DEPTH) : sum[CW-1:0];
    hx   = PW'(wp_q) + PW'(DEPTH) - PW'(fill_q);
    head = (hx >= PW'(DEPTH)) ? AW'(hx - PW'(DEPTH)) : AW'(hx);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp_q   <= '0;
      fill_q <= '0;
    end else begin
      wp_q   <= wp_n;
      fill_q <= fill_n;
    end
  end

  for (genvar g = 0; g < DEPTH; g++) begin : g_ent
    logic          we0, we1;
    logic [DW-1:0] ent_q;
    assign we0 = (wr_cnt != 2'd0) && (wp_q == AW'(g));
    assign we1 = (wr_cnt == 2'd2) && (wp1 == AW'(g));
    always_ff @(posedge clk) begin
      if (we0)      ent_q <= wr_a;
      else if (we1) ent_q <= wr_b;
    end
    assign view[g] = ent_q;
  end

  assign fill   = fill_q;
  assign oldest = view[head];
endmodule

// File: rtl/srcsave_fifo.sv
module srcsave_fifo
  import srcsave_pkg::*;
#(
  parameter int DW    = 8,
  parameter int DEPTH = 8,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [1:0]    mode_sel,
  input  logic          src1_save,
  input  logic [DW-1:0] src1_data,
  input  logic          src2_save,
  input  logic [DW-1:0] src2_data,
  output logic          stall,
  output logic [1:0]    wr_cnt,
  output logic [DW-1:0] wr_first,
  output logic [DW-1:0] wr_second,
  output logic [CW-1:0] fill,
  output logic [DW-1:0] oldest
);
  logic       rst_n_s;
  save_mode_e mode_q;

  srcsave_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_s)
  );

  srcsave_arb #(.DW(DW)) u_arb (
    .clk        (clk),
    .rst_n      (rst_n_s),
    .mode_sel   (mode_sel),
    .fifo_empty (fill == '0),
    .s1_save    (src1_save),
    .s1_data    (src1_data),
    .s2_save    (src2_save),
    .s2_data    (src2_data),
    .stall      (stall),
    .wr_cnt     (wr_cnt),
    .wr_a       (wr_first),
    .wr_b       (wr_second),
    .mode_q     (mode_q)
  );

  srcsave_ring #(.DW(DW), .DEPTH(DEPTH)) u_ring (
    .clk    (clk),
    .rst_n  (rst_n_s),
    .wr_cnt (wr_cnt),
    .wr_a   (wr_first),
    .wr_b   (wr_second),
    .fill   (fill),
    .oldest (oldest)
  );
endmodule

// File: rtl/srcsave_fifo_chk.sv
module srcsave_fifo_chk
  import srcsave_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter int CW    = 4
) (
  input logic          clk,
  input logic          rst_n,
  input save_mode_e    mode_q,
  input logic          stall,
  input logic [1:0]    wr_cnt,
  input logic [CW-1:0] fill
);
  // R2
  split_nostall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == MODE_SPLIT) |-> !stall);

  // R3
  serial_one_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == MODE_SERIAL && stall) |=> !stall);

  // R5
  staged_single_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == MODE_STAGED || mode_q == MODE_XSTAGED) |-> (wr_cnt <= 2'd1));

  // R6
  stall_drains_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((mode_q == MODE_STAGED || mode_q == MODE_XSTAGED) && stall) |-> (wr_cnt == 2'd1));

  // R8
  fill_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fill <= CW'(DEPTH));

  // R8
  fill_mono_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_cnt != 2'd0) |=> (fill >= $past(fill)) && (fill != '0));

  // R9
  mode_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fill != '0) |=> $stable(mode_q));
endmodule

bind srcsave_fifo srcsave_fifo_chk #(.DEPTH(DEPTH), .CW(CW)) u_chk (
  .clk    (clk),
  .rst_n  (rst_n_s),
  .mode_q (mode_q),
  .stall  (stall),
  .wr_cnt (wr_cnt),
  .fill   (fill)
);

// File: tb/test_srcsave_fifo.sv
module test_srcsave_fifo;
  localparam int CLK_P = 10;
  localparam int DW    = 8;
  localparam int DEPTH = 8;
  localparam int CW    = $clog2(DEPTH + 1);

  logic          clk = 1'b0;
  logic          rst_n;
  logic [1:0]    mode_sel;
  logic          src1_save, src2_save;
  logic [DW-1:0] src1_data, src2_data;
  logic          stall;
  logic [1:0]    wr_cnt;
  logic [DW-1:0] wr_first, wr_second, oldest;
  logic [CW-1:0] fill;

  int n_chk = 0;
  int n_fail = 0;

  // reference model state
  int mmode;
  bit mpend;
  bit sv[2];
  int sd[2];
  int sord[$];
  int mf[$];

  srcsave_fifo #(.DW(DW), .DEPTH(DEPTH)) i_srcsave_fifo (
    .clk(clk), .rst_n(rst_n), .mode_sel(mode_sel),
    .src1_save(src1_save), .src1_data(src1_data),
    .src2_save(src2_save), .src2_data(src2_data),
    .stall(stall), .wr_cnt(wr_cnt), .wr_first(wr_first),
    .wr_second(wr_second), .fill(fill), .oldest(oldest)
  );

  always #(CLK_P / 2) clk = ~clk;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  function automatic string mode_tag(input int m);
    case (m)
      0: return "R2";
      1: return "R3";
      2: return "R6";
      default: return "R7";
    endcase
  endfunction

  task automatic model_step(input bit a, input int da, input bit b, input int db,
                            output bit st, output int n, output int w0, output int w1);
    int wl[$];
    int nb[$];
    int nd[$];
    int ps[$];
    bit tf[2];
    bit ok;
    st = 0;
    if (mmode == 0) begin
      if (a) wl.push_back(da);
      if (b) wl.push_back(db);
    end else if (mmode == 1) begin
      if (a && b) begin
        if (!mpend) begin wl.push_back(da); st = 1; mpend = 1; end
        else begin wl.push_back(db); mpend = 0; end
      end else begin
        mpend = 0;
        if (a) wl.push_back(da);
        if (b) wl.push_back(db);
      end
    end else begin
      if (sord.size() > 0) begin
        int s;
        s = sord.pop_front();
        wl.push_back(sd[s]);
        sv[s] = 0;
      end
      if (a) begin nb.push_back(0); nd.push_back(da); end
      if (b) begin nb.push_back(1); nd.push_back(db); end
      if (wl.size() == 0 && nb.size() > 0) begin
        wl.push_back(nd[0]);
        void'(nb.pop_front());
        void'(nd.pop_front());
      end
      tf[0] = !sv[0];
      tf[1] = !sv[1];
      ok = 1;
      foreach (nb[i]) begin
        if (tf[nb[i]]) begin ps.push_back(nb[i]); tf[nb[i]] = 0; end
        else if (mmode == 3 && tf[1 - nb[i]]) begin ps.push_back(1 - nb[i]); tf[1 - nb[i]] = 0; end
        else ok = 0;
      end
      if (!ok) st = 1;
      else foreach (ps[i]) begin
        sv[ps[i]] = 1;
        sd[ps[i]] = nd[i];
        sord.push_back(ps[i]);
      end
    end
    n  = wl.size();
    w0 = (n > 0) ? wl[0] : 0;
    w1 = (n > 1) ? wl[1] : 0;
    foreach (wl[i]) mf.push_back(wl[i]);
    while (mf.size() > DEPTH) void'(mf.pop_front());
  endtask

  task automatic cycle(input int md, input bit a, input int da, input bit b, input int db,
                       output bit st_act, output int cnt_act);
    bit est;
    bit emp;
    int en, e0, e1;
    string tg;
    @(negedge clk);
    mode_sel  = md[1:0];
    src1_save = a; src1_data = da[DW-1:0];
    src2_save = b; src2_data = db[DW-1:0];
    #2;
    chk(int'(fill) == mf.size(), "R8", int'(fill), mf.size());
    if (mf.size() > 0) chk(int'(oldest) == mf[0], "R8", int'(oldest), mf[0]);
    tg  = mode_tag(mmode);
    emp = (mf.size() == 0) && (sord.size() == 0) && !mpend;
    model_step(a, da, b, db, est, en, e0, e1);
    chk(stall == est, tg, int'(stall), int'(est));
    chk(int'(wr_cnt) == en, tg, int'(wr_cnt), en);
    if (en > 0) chk(int'(wr_first) == e0, (mmode >= 2) ? "R5" : tg, int'(wr_first), e0);
    if (en == 2) chk(int'(wr_second) == e1, "R2", int'(wr_second), e1);
    if (emp) mmode = md;
    st_act  = stall;
    cnt_act = int'(wr_cnt);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    mode_sel = 2'd0; src1_save = 0; src2_save = 0; src1_data = '0; src2_data = '0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    mmode = 0; mpend = 0; sv[0] = 0; sv[1] = 0;
    sord.delete(); mf.delete();
  endtask

  initial begin
    #(CLK_P * 150000);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

  initial begin
    bit st;
    int c;
    void'($urandom(32'd4242));
    rst_n = 1'b0;
    do_reset();

    // R1: reset state
    #2;
    chk(fill == '0, "R1", int'(fill), 0);
    chk(stall == 1'b0, "R1", int'(stall), 0);
    cycle(0, 0, 0, 0, 0, st, c);
    chk(c == 0, "R1", c, 0);
    // R1/R2: split default after reset
    cycle(0, 1, 8'h11, 1, 8'h22, st, c);
    chk(c == 2 && !st, "R2", c, 2);

    // R3: serial mode stalls once
    do_reset();
    cycle(1, 0, 0, 0, 0, st, c);
    cycle(1, 1, 8'h31, 1, 8'h32, st, c);
    chk(st == 1, "R3", int'(st), 1);
    cycle(1, 1, 8'h31, 1, 8'h32, st, c);
    chk(st == 0, "R3", int'(st), 0);
    chk(wr_first == 8'h32, "R3", int'(wr_first), 8'h32);

    // R4/R5/R6: staged mode
    do_reset();
    cycle(2, 0, 0, 0, 0, st, c);
    cycle(2, 1, 8'hA1, 1, 8'hA2, st, c);
    chk(c == 1 && !st, "R4", c, 1);
    cycle(2, 1, 8'hB1, 1, 8'hB2, st, c);
    chk(wr_first == 8'hA2, "R5", int'(wr_first), 8'hA2);
    cycle(2, 0, 0, 1, 8'hC2, st, c);
    chk(st == 1, "R6", int'(st), 1);
    chk(wr_first == 8'hB1, "R6", int'(wr_first), 8'hB1);
    cycle(2, 0, 0, 1, 8'hC2, st, c);
    chk(st == 0, "R6", int'(st), 0);
    chk(wr_first == 8'hB2, "R5", int'(wr_first), 8'hB2);

    // R7: cross-staged avoids that stall
    do_reset();
    cycle(3, 0, 0, 0, 0, st, c);
    cycle(3, 1, 8'hA1, 1, 8'hA2, st, c);
    cycle(3, 1, 8'hB1, 1, 8'hB2, st, c);
    cycle(3, 0, 0, 1, 8'hC2, st, c);
    chk(st == 0, "R7", int'(st), 0);
    // R9: mode change ignored while not empty
    repeat (3) cycle(0, 0, 0, 0, 0, st, c);
    cycle(0, 1, 8'hD1, 1, 8'hD2, st, c);
    chk(c == 1, "R9", c, 1);

    // R8: saturation and discard
    do_reset();
    cycle(0, 0, 0, 0, 0, st, c);
    for (int i = 0; i < DEPTH + 3; i++) cycle(0, 1, 8'h40 + i, 0, 0, st, c);
    cycle(0, 0, 0, 0, 0, st, c);
    chk(fill == CW'(DEPTH), "R8", int'(fill), DEPTH);
    chk(oldest == 8'h43, "R8", int'(oldest), 8'h43);

    // random episodes across all modes
    for (int ep = 0; ep < 12; ep++) begin
      bit a, b;
      int da, db;
      do_reset();
      cycle(ep % 4, 0, 0, 0, 0, st, c);
      st = 0;
      a = 0; b = 0; da = 0; db = 0;
      for (int k = 0; k < 150; k++) begin
        if (!st) begin
          a  = ($urandom % 3) != 0;
          b  = ($urandom % 3) != 0;
          da = $urandom % 256;
          db = $urandom % 256;
        end
        cycle(($urandom % 4), a, da, b, db, st, c);
      end
    end

    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end
endmodule